// File: doc/BRIEF.md
# Smart Card Early Answer Detector

This block watches a smart card's reset line and I/O line during the answer-to-reset phase. It catches a card that starts transmitting sooner than allowed. It counts card clock cycles, one per enabled system clock, in two phases:

- the low phase begins when the reset line falls;
- the high phase begins when the reset line rises.

The count is compared against fixed windows. Inside an early-answer window, the I/O line is checked for a start bit only at sampling points spaced 46 card clocks apart. The last 32 clocks of each early-answer window form a blind interval.

The block has three outputs:

- a sticky early-answer status bit;
- an interrupt request that follows that status bit;
- a one-cycle pulse marking a start bit that counts as a received character.

A controller uses the pulse to decide whether the answer already under way should be accepted. It uses the status bit to record that the card answered early. The block only accepts the first start bit in each phase. Control and status pins are plain levels or strobes; there is no data stream and no handshake.

Top module: `sc_early_answer_det`

## Requirements
- R1: The cycle count starts at 0 after system reset and advances only on cycles with `card_clk_en` high. It restarts at 0 on every edge of `rst_line`. It saturates at 4000 instead of wrapping. The cycle in which a `rst_line` edge is first seen evaluates no start bit.
- R2: In the reset-low phase, a start bit (`io_in` low on an enabled cycle) at a sampling point with count 200 to 335 sets `ea_status` and produces a received pulse.
- R3: In the reset-high phase, a start bit at a sampling point with count 0 to 335 sets `ea_status` and produces a received pulse.
- R4: Sampling points inside an early-answer window fall every 46 counts from the window's first count (200 in the low phase, 0 in the high phase). A low `io_in` between sampling points inside such a window is not detected.
- R5: A low `io_in` at counts 336 to 367 (the blind interval) in either phase is neither flagged nor received, including at a count that would otherwise be a sampling point.
- R6: In the reset-low phase, a low `io_in` at count below 200 or at 400 and above has no effect. At counts 368 to 399 it produces a received pulse without setting `ea_status`.
- R7: In the reset-high phase, a low `io_in` at counts 368 to 3999 produces a received pulse without setting `ea_status`. Once the count has saturated it has no effect.
- R8: Only the first start bit detected in a phase is acted on. A later low `io_in` in the same phase produces no pulse and no status change.
- R9: `ea_status` is 0 after system reset. Once set it stays set until `clr` is high or a falling edge of `rst_line` is seen. If a set and `clr` coincide, the set wins.
- R10: `irq` is high exactly when `ea_status` is high.
- R11: `char_rx` is high for exactly the one cycle after the clock edge that detected a received start bit. At that same point `ea_status` shows the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| card_clk_en | input | 1 | High on cycles that carry one card clock |
| rst_line | input | 1 | Card reset line level, synchronous to clk |
| io_in | input | 1 | Sampled card I/O line, synchronous to clk, low means start bit |
| clr | input | 1 | Clears the early-answer status bit |
| ea_status | output | 1 | Sticky early-answer flag |
| irq | output | 1 | Interrupt request, follows `ea_status` |
| char_rx | output | 1 | One-cycle pulse: a start bit counted as a received character |

## Verification
The assertions take `rst_line` and `io_in` to be synchronous to `clk` already, with no metastability filtering inside the block. They also take `clr` to be a plain level that may coincide with a detection. The bench changes every input only on the falling clock edge. It holds `rst_line` steady for at least two cycles around each edge, so every phase restart is seen cleanly. The bench pulls `io_in` low for single cycles at chosen counts, with one exception: in the clock-enable test it is held low while `card_clk_en` is low.

// File: rtl/eaw_pkg.sv
package eaw_pkg;
  typedef enum logic [1:0] {
    REG_NONE  = 2'd0,
    REG_EA    = 2'd1,
    REG_BLIND = 2'd2,
    REG_RX    = 2'd3
  } region_t;
endpackage

// File: rtl/eaw_cycle_counter.sv
module eaw_cycle_counter #(
  parameter int CNT_MAX     = 4000,
  parameter int CNT_W       = 12,
  parameter int SAMPLE_PER  = 46,
  parameter int LO_EA_START = 200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             card_clk_en,
  input  logic             rst_line,
  output logic [CNT_W-1:0] cnt,
  output logic             phase_hi,
  output logic             restart,
  output logic             falling,
  output logic             samp_tick
);
  localparam int SW = (SAMPLE_PER > 1) ? $clog2(SAMPLE_PER) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX_C   = CNT_W'(CNT_MAX);
  localparam logic [CNT_W-1:0] LO_PRE_C    = CNT_W'(LO_EA_START - 1);
  localparam logic [SW-1:0]    SAMP_LAST_C = SW'(SAMPLE_PER - 1);

  logic          rst_q;
  logic [SW-1:0] samp;

  assign restart   = rst_line ^ rst_q;
  assign falling   = rst_q & ~rst_line;
  assign phase_hi  = rst_q;
  assign samp_tick = (samp == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q <= 1'b0;
      cnt   <= '0;
      samp  <= '0;
    end else begin
      rst_q <= rst_line;
      if (restart) begin
        cnt  <= '0;
        samp <= '0;
      end else if (card_clk_en) begin
        if (cnt != CNT_MAX_C) cnt <= cnt + 1'b1;
        // low phase: realign sampling grid so that the window start is a point
        if (!rst_q && cnt == LO_PRE_C) samp <= '0;
        else if (samp == SAMP_LAST_C)  samp <= '0;
        else                           samp <= samp + 1'b1;
      end
    end
  end
endmodule

// File: rtl/eaw_window_decode.sv
module eaw_window_decode
  import eaw_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int LO_EA_START = 200,
  parameter int EA_END      = 368,
  parameter int BLIND       = 32,
  parameter int LO_RX_END   = 400,
  parameter int HI_RX_END   = 4000
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic             phase_hi,
  output region_t          region
);
  localparam logic [CNT_W-1:0] LO_EA_C  = CNT_W'(LO_EA_START);
  localparam logic [CNT_W-1:0] BLIND_C  = CNT_W'(EA_END - BLIND);
  localparam logic [CNT_W-1:0] EA_END_C = CNT_W'(EA_END);
  localparam logic [CNT_W-1:0] LO_RX_C  = CNT_W'(LO_RX_END);
  localparam logic [CNT_W-1:0] HI_RX_C  = CNT_W'(HI_RX_END);

  logic [CNT_W-1:0] rx_end;
  logic             before_ea;

  assign rx_end    = phase_hi ? HI_RX_C : LO_RX_C;
  assign before_ea = !phase_hi && (cnt < LO_EA_C);

  always_comb begin
    if (before_ea)           region = REG_NONE;
    else if (cnt < BLIND_C)  region = REG_EA;
    else if (cnt < EA_END_C) region = REG_BLIND;
    else if (cnt < rx_end)   region = REG_RX;
    else                     region = REG_NONE;
  end
endmodule

// File: rtl/eaw_status.sv
module eaw_status
  import eaw_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    card_clk_en,
  input  logic    restart,
  input  logic    falling,
  input  logic    clr,
  input  logic    io_in,
  input  logic    samp_tick,
  input  region_t region,
  output logic    ea_q,
  output logic    rx_q
);
  logic armed;
  logic hit_ea;
  logic hit_rx;
  logic detect;

  assign hit_ea = (region == REG_EA) && samp_tick;
  assign hit_rx = (region == REG_RX);
  assign detect = card_clk_en && !restart && armed && !io_in && (hit_ea || hit_rx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b1;
      ea_q  <= 1'b0;
      rx_q  <= 1'b0;
    end else begin
      rx_q <= detect;
      if (restart)     armed <= 1'b1;
      else if (detect) armed <= 1'b0;
      if (detect && hit_ea)    ea_q <= 1'b1;
      else if (clr || falling) ea_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sc_early_answer_det.sv
module sc_early_answer_det
  import eaw_pkg::*;
#(
  parameter int LO_EA_START = 200,
  parameter int EA_END      = 368,
  parameter int BLIND       = 32,
  parameter int LO_RX_END   = 400,
  parameter int HI_RX_END   = 4000,
  parameter int SAMPLE_PER  = 46
) (
  input  logic clk,
  input  logic rst_n,
  input  logic card_clk_en,
  input  logic rst_line,
  input  logic io_in,
  input  logic clr,
  output logic ea_status,
  output logic irq,
  output logic char_rx
);
  localparam int CNT_W = $clog2(HI_RX_END + 1);

  logic [CNT_W-1:0] cnt_w;
  logic             phase_hi;
  logic             restart;
  logic             falling;
  logic             samp_tick;
  region_t          region;

  eaw_cycle_counter #(
    .CNT_MAX(HI_RX_END), .CNT_W(CNT_W),
    .SAMPLE_PER(SAMPLE_PER), .LO_EA_START(LO_EA_START)
  ) u_cnt (
    .clk(clk), .rst_n(rst_n), .card_clk_en(card_clk_en), .rst_line(rst_line),
    .cnt(cnt_w), .phase_hi(phase_hi), .restart(restart), .falling(falling),
    .samp_tick(samp_tick)
  );

  eaw_window_decode #(
    .CNT_W(CNT_W), .LO_EA_START(LO_EA_START), .EA_END(EA_END),
    .BLIND(BLIND), .LO_RX_END(LO_RX_END), .HI_RX_END(HI_RX_END)
  ) u_dec (
    .cnt(cnt_w), .phase_hi(phase_hi), .region(region)
  );

  eaw_status u_stat (
    .clk(clk), .rst_n(rst_n), .card_clk_en(card_clk_en), .restart(restart),
    .falling(falling), .clr(clr), .io_in(io_in), .samp_tick(samp_tick),
    .region(region), .ea_q(ea_status), .rx_q(char_rx)
  );

  assign irq = ea_status;
endmodule

// File: rtl/sc_early_answer_det_chk.sv
module sc_early_answer_det_chk #(
  parameter int CNT_MAX = 4000,
  parameter int CNT_W   = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             card_clk_en,
  input logic             clr,
  input logic             restart,
  input logic             falling,
  input logic [CNT_W-1:0] cnt,
  input logic             ea_status,
  input logic             irq,
  input logic             char_rx
);
  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(CNT_MAX);

  assert_cnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= MAX_C);

  assert_cnt_sat_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == MAX_C && !restart) |=> cnt == MAX_C);

  assert_rx_needs_clk_R1: assert property (@(posedge clk) disable iff (!rst_n)
    char_rx |-> $past(card_clk_en));

  assert_ea_with_rx_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ea_status) |-> char_rx);

  assert_single_rx_R8: assert property (@(posedge clk) disable iff (!rst_n)
    char_rx |=> !char_rx);

  assert_ea_clear_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ea_status) |-> $past(clr || falling));

  assert_irq_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq == ea_status);
endmodule

bind sc_early_answer_det sc_early_answer_det_chk #(
  .CNT_MAX(HI_RX_END), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .card_clk_en(card_clk_en), .clr(clr),
  .restart(restart), .falling(falling), .cnt(cnt_w),
  .ea_status(ea_status), .irq(irq), .char_rx(char_rx)
);

// File: tb/tb_sc_early_answer_det.sv
module tb_sc_early_answer_det;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic card_clk_en = 1'b1;
  logic rst_line = 1'b0;
  logic io_in = 1'b1;
  logic clr = 1'b0;
  logic ea_status, irq, char_rx;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  sc_early_answer_det dut (
    .clk(clk), .rst_n(rst_n), .card_clk_en(card_clk_en), .rst_line(rst_line),
    .io_in(io_in), .clr(clr), .ea_status(ea_status), .irq(irq), .char_rx(char_rx)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input logic exp_ea, input logic exp_rx);
    chk(req, "ea_status", ea_status, exp_ea);
    chk(req, "irq", irq, exp_ea);
    chk(req, "char_rx", char_rx, exp_rx);
  endtask

  // leaves the count at 0 in the requested phase, ea cleared by a falling edge
  task automatic fresh(input logic lvl);
    rst_line = 1'b1;
    repeat (2) @(negedge clk);
    rst_line = 1'b0;
    @(negedge clk);
    if (lvl) begin
      @(negedge clk);
      rst_line = 1'b1;
      @(negedge clk);
    end
  endtask

  task automatic advance(input int n);
    repeat (n) @(negedge clk);
  endtask

  // io low for the enabled cycle at the current count; count advances by one
  task automatic strobe(input string req, input logic exp_ea, input logic exp_rx);
    io_in = 1'b0;
    @(negedge clk);
    io_in = 1'b1;
    chk_out(req, exp_ea, exp_rx);
  endtask

  task automatic t_reset;
    chk_out("R9", 1'b0, 1'b0);
  endtask

  task automatic t_low_windows;
    fresh(1'b0); advance(100); strobe("R6 low c100", 1'b0, 1'b0);
    fresh(1'b0); advance(200); strobe("R2 low c200", 1'b1, 1'b1);
    @(negedge clk); chk("R11", "char_rx pulse end", char_rx, 1'b0);
    fresh(1'b0); advance(246); strobe("R2 low c246", 1'b1, 1'b1);
    fresh(1'b0); advance(201); strobe("R4 low c201", 1'b0, 1'b0);
    advance(44); strobe("R4 low c246 after miss", 1'b1, 1'b1);
    fresh(1'b0); advance(338); strobe("R5 low c338", 1'b0, 1'b0);
    fresh(1'b0); advance(370); strobe("R6 low c370", 1'b0, 1'b1);
    fresh(1'b0); advance(450); strobe("R6 low c450", 1'b0, 1'b0);
  endtask

  task automatic t_high_windows;
    fresh(1'b1); strobe("R3 high c0", 1'b1, 1'b1);
    fresh(1'b1); advance(30); strobe("R4 high c30", 1'b0, 1'b0);
    fresh(1'b1); advance(46); strobe("R3 high c46", 1'b1, 1'b1);
    fresh(1'b1); advance(322); strobe("R3 high c322", 1'b1, 1'b1);
    fresh(1'b1); advance(340); strobe("R5 high c340", 1'b0, 1'b0);
    fresh(1'b1); advance(1000); strobe("R7 high c1000", 1'b0, 1'b1);
    fresh(1'b1); advance(4100); strobe("R7 high saturated", 1'b0, 1'b0);
  endtask

  task automatic t_first_only;
    fresh(1'b1); strobe("R8 first", 1'b1, 1'b1);
    advance(999); strobe("R8 second ignored", 1'b1, 1'b0);
    fresh(1'b0); advance(380); strobe("R8 first rx", 1'b0, 1'b1);
    advance(5); strobe("R8 second rx ignored", 1'b0, 1'b0);
  endtask

  task automatic t_clear;
    fresh(1'b1); strobe("R9 set", 1'b1, 1'b1);
    advance(10); chk("R9", "sticky", ea_status, 1'b1);
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    chk_out("R9 clr", 1'b0, 1'b0);
    fresh(1'b1); advance(92);
    clr = 1'b1; io_in = 1'b0; @(negedge clk); clr = 1'b0; io_in = 1'b1;
    chk_out("R9 set beats clr", 1'b1, 1'b1);
    advance(3); rst_line = 1'b0; @(negedge clk);
    chk("R9", "falling reset clears", ea_status, 1'b0);
    chk("R10", "irq low after clear", irq, 1'b0);
  endtask

  task automatic t_clk_en;
    fresh(1'b0); advance(246);
    card_clk_en = 1'b0; io_in = 1'b0;
    advance(3);
    chk_out("R1 no clock no detect", 1'b0, 1'b0);
    io_in = 1'b1; advance(2);
    card_clk_en = 1'b1;
    strobe("R1 gated count c246", 1'b1, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_low_windows();
    t_high_windows();
    t_first_only();
    t_clear();
    t_clk_en();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule